// File: doc/BRIEF.md
# Dual-Bank Row-Pair Address Router

This block takes a stream of linear two-dimensional addresses together with a stream of paired data words. It splits each access across two parallel memory banks so that an image row and its partner row (the row that differs only in the lowest y bit) are reached in the same beat. The address is treated as an x field in the low bits with a y field above it. The parameter `YLSB` gives the bit position where the y field starts.

That y bit picks the bank for the addressed row. It is then taken out of the address: the x bits below it stay where they are, and every bit above it moves down one place. Both banks receive this shortened address. The near data word goes to the bank that holds the addressed row, and the far word goes to the other bank. A registered route select output shows whether the two lanes are passed straight or crossed.

The address and data inputs are joined: a beat enters only when both streams present valid in the same cycle. The block has two register stages, mapping first and lane steering second. Each bank port completes its handshake on its own. A new beat moves into the bank stage only after both banks have taken the current one. Back-pressure from either bank therefore fills the mapping stage and then deasserts both input readies.

Top module: `bank_pair_router`

## Requirements
- R1: The bank whose index equals bit `YLSB` of the accepted address (0 or 1) receives the near data word of that beat.
- R2: The bank address is `ADDR_W-1` bits wide. Bits `YLSB-1..0` equal the same bits of the input address, and bit i for i >= `YLSB` equals input bit i+1.
- R3: Both banks receive the same bank address for a given beat.
- R4: The bank not selected by bit `YLSB` receives the far data word. While a beat is presented, `cross_sel` equals bit `YLSB` of its address (0 = near word to bank 0, 1 = near word to bank 1).
- R5: A beat is taken only when `addr_valid` and `dat_valid` are both high and the block is ready. `addr_ready` is never high while `dat_valid` is low, and `dat_ready` is never high while `addr_valid` is low.
- R6: A beat accepted at clock edge t, with both stages empty, is not yet at the bank ports after edge t. It is presented at both bank ports after edge t+1.
- R7: A bank port holding valid without ready keeps valid, address, data and `cross_sel` unchanged at the next edge. Once the bank accepts, its valid stays low until the next beat is loaded.
- R8: While one bank stalls, the other bank receives no further beat. At most two beats are accepted beyond those the stalled bank has taken, after which both input readies stay low.
- R9: Each bank receives every accepted beat exactly once, in acceptance order.
- R10: After reset, both bank valids are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_valid | input | 1 | Address stream valid |
| addr_ready | output | 1 | Address stream ready |
| addr_in | input | ADDR_W | Linear address (x field below `YLSB`, y field from `YLSB` up) |
| dat_valid | input | 1 | Data stream valid |
| dat_ready | output | 1 | Data stream ready |
| dat_near | input | DATA_W | Word for the addressed row |
| dat_far | input | DATA_W | Word for the partner row |
| bank0_valid | output | 1 | Bank 0 request valid |
| bank0_ready | input | 1 | Bank 0 request ready |
| bank0_addr | output | ADDR_W-1 | Bank 0 address, with the bank bit removed |
| bank0_data | output | DATA_W | Bank 0 data word |
| bank1_valid | output | 1 | Bank 1 request valid |
| bank1_ready | input | 1 | Bank 1 request ready |
| bank1_addr | output | ADDR_W-1 | Bank 1 address, with the bank bit removed |
| bank1_data | output | DATA_W | Bank 1 data word |
| cross_sel | output | 1 | Route select of the presented beat: 0 straight, 1 crossed |

## Verification
Two functions can meet in one clock: one bank completes its handshake while the other stalls, and the bank stage can empty in the same edge that the mapping stage hands it the next beat. A sweep over every address of a 10-bit configuration drives independent pseudo-random readies on the two banks and gaps on both input streams, so single-bank completions, joint completions and same-edge reloads all occur. Each bank is judged against its own ordered record of accepted beats, using an arithmetic model of the bit removal. A held stall of bank 1 then confirms that bank 0 drains exactly one beat and the input closes after two.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

  localparam int unsigned NUM_BANKS = 2;

  typedef enum logic {
    ROUTE_STRAIGHT = 1'b0,
    ROUTE_CROSSED  = 1'b1
  } route_e;

endpackage

// File: rtl/bsr_addr_map.sv
// Splits a linear address into a bank bit and a bank-local address.
// The bank bit is dropped by re-indexing wires: no shifter is built.
module bsr_addr_map #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned YLSB   = 6
) (
  input  logic [ADDR_W-1:0] lin_addr,
  output logic [ADDR_W-2:0] bank_addr,
  output logic              bank_bit
);

  localparam int unsigned MAP_W = ADDR_W - 1;

  assign bank_bit = lin_addr[YLSB];

  for (genvar i = 0; i < MAP_W; i++) begin : g_bit
    if (i < YLSB) begin : g_x_field
      assign bank_addr[i] = lin_addr[i];
    end else begin : g_y_field
      assign bank_addr[i] = lin_addr[i+1];
    end
  end

endmodule

// File: rtl/bsr_map_stage.sv
// First register stage: joins the address and data streams, maps the address.
module bsr_map_stage
  import bsr_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned YLSB   = 6,
  parameter int unsigned DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                addr_valid,
  output logic                addr_ready,
  input  logic [ADDR_W-1:0]   addr_in,
  input  logic                dat_valid,
  output logic                dat_ready,
  input  logic [DATA_W-1:0]   dat_near,
  input  logic [DATA_W-1:0]   dat_far,
  output logic                m_valid,
  input  logic                m_ready,
  output logic [ADDR_W-2:0]   m_addr,
  output route_e              m_route,
  output logic [DATA_W-1:0]   m_near,
  output logic [DATA_W-1:0]   m_far
);

  localparam int unsigned MAP_W = ADDR_W - 1;

  logic             s1_valid;
  logic             take;
  logic             join_fire;
  logic [MAP_W-1:0] mapped;
  logic             bank_bit;

  bsr_addr_map #(
    .ADDR_W (ADDR_W),
    .YLSB   (YLSB)
  ) u_map (
    .lin_addr  (addr_in),
    .bank_addr (mapped),
    .bank_bit  (bank_bit)
  );

  // The stage can take a beat when empty or when it is being drained.
  assign take       = !s1_valid || m_ready;
  assign addr_ready = take && dat_valid;
  assign dat_ready  = take && addr_valid;
  assign join_fire  = take && addr_valid && dat_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
    end else if (take) begin
      s1_valid <= addr_valid && dat_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (join_fire) begin
      m_addr  <= mapped;
      m_route <= route_e'(bank_bit);
      m_near  <= dat_near;
      m_far   <= dat_far;
    end
  end

  assign m_valid = s1_valid;

endmodule

// File: rtl/bsr_swap_stage.sv
// Second register stage: steers the two data lanes to the banks and tracks
// which banks still owe a handshake for the held beat.
module bsr_swap_stage
  import bsr_pkg::*;
#(
  parameter int unsigned MAP_W  = 19,
  parameter int unsigned DATA_W = 32
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 m_valid,
  output logic                                 m_ready,
  input  logic [MAP_W-1:0]                     m_addr,
  input  route_e                               m_route,
  input  logic [DATA_W-1:0]                    m_near,
  input  logic [DATA_W-1:0]                    m_far,
  output logic [NUM_BANKS-1:0]                 bk_valid,
  input  logic [NUM_BANKS-1:0]                 bk_ready,
  output logic [MAP_W-1:0]                     bk_addr,
  output logic [NUM_BANKS-1:0][DATA_W-1:0]     bk_data,
  output route_e                               route_sel
);

  logic [NUM_BANKS-1:0] pend;
  logic [NUM_BANKS-1:0] done_ok;
  logic                 free;
  logic                 load;

  // Each bank is either idle or finishing in this cycle.
  assign done_ok = ~pend | bk_ready;
  assign free    = &done_ok;
  assign load    = m_valid && free;
  assign m_ready = free;

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
    localparam bit ODD_BANK = (k == 1);
    logic              pend_q;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_q <= 1'b0;
      end else if (load) begin
        pend_q <= 1'b1;
      end else if (bk_ready[k]) begin
        pend_q <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (load) begin
        data_q <= ((m_route == ROUTE_CROSSED) == ODD_BANK) ? m_near : m_far;
      end
    end

    assign pend[k]     = pend_q;
    assign bk_valid[k] = pend_q;
    assign bk_data[k]  = data_q;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      bk_addr   <= m_addr;
      route_sel <= m_route;
    end
  end

endmodule

// File: rtl/bank_pair_router.sv
module bank_pair_router
  import bsr_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned YLSB   = 6,
  parameter int unsigned DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                addr_valid,
  output logic                addr_ready,
  input  logic [ADDR_W-1:0]   addr_in,
  input  logic                dat_valid,
  output logic                dat_ready,
  input  logic [DATA_W-1:0]   dat_near,
  input  logic [DATA_W-1:0]   dat_far,
  output logic                bank0_valid,
  input  logic                bank0_ready,
  output logic [ADDR_W-2:0]   bank0_addr,
  output logic [DATA_W-1:0]   bank0_data,
  output logic                bank1_valid,
  input  logic                bank1_ready,
  output logic [ADDR_W-2:0]   bank1_addr,
  output logic [DATA_W-1:0]   bank1_data,
  output logic                cross_sel
);

  localparam int unsigned MAP_W = ADDR_W - 1;

  logic                             m_valid;
  logic                             m_ready;
  logic [MAP_W-1:0]                 m_addr;
  route_e                           m_route;
  logic [DATA_W-1:0]                m_near;
  logic [DATA_W-1:0]                m_far;
  logic [NUM_BANKS-1:0]             bk_valid;
  logic [NUM_BANKS-1:0]             bk_ready;
  logic [MAP_W-1:0]                 bk_addr;
  logic [NUM_BANKS-1:0][DATA_W-1:0] bk_data;
  route_e                           route_sel;

  bsr_map_stage #(
    .ADDR_W (ADDR_W),
    .YLSB   (YLSB),
    .DATA_W (DATA_W)
  ) u_map_stage (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_valid (addr_valid),
    .addr_ready (addr_ready),
    .addr_in    (addr_in),
    .dat_valid  (dat_valid),
    .dat_ready  (dat_ready),
    .dat_near   (dat_near),
    .dat_far    (dat_far),
    .m_valid    (m_valid),
    .m_ready    (m_ready),
    .m_addr     (m_addr),
    .m_route    (m_route),
    .m_near     (m_near),
    .m_far      (m_far)
  );

  bsr_swap_stage #(
    .MAP_W  (MAP_W),
    .DATA_W (DATA_W)
  ) u_swap_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .m_valid   (m_valid),
    .m_ready   (m_ready),
    .m_addr    (m_addr),
    .m_route   (m_route),
    .m_near    (m_near),
    .m_far     (m_far),
    .bk_valid  (bk_valid),
    .bk_ready  (bk_ready),
    .bk_addr   (bk_addr),
    .bk_data   (bk_data),
    .route_sel (route_sel)
  );

  assign bk_ready    = {bank1_ready, bank0_ready};
  assign bank0_valid = bk_valid[0];
  assign bank1_valid = bk_valid[1];
  assign bank0_addr  = bk_addr;
  assign bank1_addr  = bk_addr;
  assign bank0_data  = bk_data[0];
  assign bank1_data  = bk_data[1];
  assign cross_sel   = route_sel;

endmodule

// File: rtl/bank_pair_router_checker.sv
module bank_pair_router_checker #(
  parameter int unsigned MAP_W  = 19,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              addr_valid,
  input logic              addr_ready,
  input logic              dat_valid,
  input logic              dat_ready,
  input logic              bank0_valid,
  input logic              bank0_ready,
  input logic [MAP_W-1:0]  bank0_addr,
  input logic [DATA_W-1:0] bank0_data,
  input logic              bank1_valid,
  input logic              bank1_ready,
  input logic [MAP_W-1:0]  bank1_addr,
  input logic [DATA_W-1:0] bank1_data,
  input logic              cross_sel
);

  a_r5_addr_ready_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ready |-> dat_valid);

  a_r5_dat_ready_needs_addr: assert property (@(posedge clk) disable iff (!rst_n)
    dat_ready |-> addr_valid);

  a_r7_bank0_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bank0_valid && !bank0_ready) |=>
      (bank0_valid && $stable(bank0_addr) && $stable(bank0_data) && $stable(cross_sel)));

  a_r7_bank1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bank1_valid && !bank1_ready) |=>
      (bank1_valid && $stable(bank1_addr) && $stable(bank1_data) && $stable(cross_sel)));

  a_r8_bank0_stall_blocks_bank1: assert property (@(posedge clk) disable iff (!rst_n)
    (bank0_valid && !bank0_ready) |=> !$rose(bank1_valid));

  a_r8_bank1_stall_blocks_bank0: assert property (@(posedge clk) disable iff (!rst_n)
    (bank1_valid && !bank1_ready) |=> !$rose(bank0_valid));

  a_r10_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!bank0_valid && !bank1_valid));

endmodule

bind bank_pair_router bank_pair_router_checker #(
  .MAP_W  (MAP_W),
  .DATA_W (DATA_W)
) u_checker (.*);

// File: tb/bank_pair_router_tb.sv
`timescale 1ns/100ps
module bank_pair_router_tb;

  localparam int AW = 10;
  localparam int YL = 4;
  localparam int DW = 16;
  localparam int MW = AW - 1;
  localparam int LOGN = 2048;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          addr_valid = 1'b0;
  logic          addr_ready;
  logic [AW-1:0] addr_in = '0;
  logic          dat_valid = 1'b0;
  logic          dat_ready;
  logic [DW-1:0] dat_near = '0;
  logic [DW-1:0] dat_far = '0;
  logic          bank0_valid;
  logic          bank0_ready = 1'b0;
  logic [MW-1:0] bank0_addr;
  logic [DW-1:0] bank0_data;
  logic          bank1_valid;
  logic          bank1_ready = 1'b0;
  logic [MW-1:0] bank1_addr;
  logic [DW-1:0] bank1_data;
  logic          cross_sel;

  always #2 clk = ~clk;

  bank_pair_router #(.ADDR_W(AW), .YLSB(YL), .DATA_W(DW)) u_dut (
    .clk (clk), .rst_n (rst_n),
    .addr_valid (addr_valid), .addr_ready (addr_ready), .addr_in (addr_in),
    .dat_valid (dat_valid), .dat_ready (dat_ready),
    .dat_near (dat_near), .dat_far (dat_far),
    .bank0_valid (bank0_valid), .bank0_ready (bank0_ready),
    .bank0_addr (bank0_addr), .bank0_data (bank0_data),
    .bank1_valid (bank1_valid), .bank1_ready (bank1_ready),
    .bank1_addr (bank1_addr), .bank1_data (bank1_data),
    .cross_sel (cross_sel)
  );

  int checks = 0;
  int errors = 0;
  int wr = 0;
  int rd0 = 0;
  int rd1 = 0;
  logic [AW-1:0] log_a [LOGN];
  logic [DW-1:0] log_n [LOGN];
  logic [DW-1:0] log_f [LOGN];

  // next-cycle drive values
  logic          nx_av = 1'b0, nx_dv = 1'b0, nx_r0 = 1'b0, nx_r1 = 1'b0;
  logic [AW-1:0] nx_addr = '0;

  function automatic logic [MW-1:0] map_ref(logic [AW-1:0] a);
    logic [AW-1:0] t;
    t = ((a >> (YL + 1)) << YL) | (a & AW'((1 << YL) - 1));
    return t[MW-1:0];
  endfunction

  function automatic logic [DW-1:0] near_of(logic [AW-1:0] a);
    return DW'(a) * 16'd7 + 16'd3;
  endfunction

  function automatic logic [DW-1:0] far_of(logic [AW-1:0] a);
    return DW'(a) ^ 16'h5a3c;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_bank(input int k, input logic [MW-1:0] ba, input logic [DW-1:0] bd);
    int i;
    logic b;
    i = (k == 0) ? rd0 : rd1;
    if (i >= wr) begin
      chk(1'b0, "R9", "bank transfer without accepted beat", i, wr);
      return;
    end
    b = log_a[i][YL];
    chk(ba == map_ref(log_a[i]), (k == 0) ? "R2" : "R3", "bank address",
        int'(ba), int'(map_ref(log_a[i])));
    if (int'(b) == k)
      chk(bd == log_n[i], "R1", "near word at selected bank", int'(bd), int'(log_n[i]));
    else
      chk(bd == log_f[i], "R4", "far word at partner bank", int'(bd), int'(log_f[i]));
    chk(cross_sel == b, "R4", "route select", int'(cross_sel), int'(b));
    if (k == 0) rd0++; else rd1++;
  endtask

  // One clock: drive at the falling edge, sample 1 ns later (1 ns before rise).
  task automatic cycle(output bit acc);
    @(negedge clk);
    addr_valid  = nx_av;
    dat_valid   = nx_dv;
    addr_in     = nx_addr;
    dat_near    = near_of(nx_addr);
    dat_far     = far_of(nx_addr);
    bank0_ready = nx_r0;
    bank1_ready = nx_r1;
    #1;
    if ((addr_ready && !dat_valid) || (dat_ready && !addr_valid))
      chk(1'b0, "R5", "ready without partner valid", int'({addr_ready, dat_ready}),
          int'({addr_valid, dat_valid}));
    acc = addr_valid && dat_valid && addr_ready;
    if (acc) begin
      chk(dat_ready == 1'b1, "R5", "joined readies", int'(dat_ready), 1);
      log_a[wr] = addr_in;
      log_n[wr] = dat_near;
      log_f[wr] = dat_far;
      wr++;
    end
    if (bank0_valid && bank0_ready) check_bank(0, bank0_addr, bank0_data);
    if (bank1_valid && bank1_ready) check_bank(1, bank1_addr, bank1_data);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R9 watchdog expired: actual=%0d expected=%0d", rd1, wr);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit acc;
    int idx;
    int w0, r0s, r1s;
    logic [15:0] lfsr;

    repeat (4) @(negedge clk);
    #1;
    chk(!bank0_valid && !bank1_valid, "R10", "valids in reset",
        int'({bank0_valid, bank1_valid}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(!bank0_valid && !bank1_valid, "R10", "valids after reset",
        int'({bank0_valid, bank1_valid}), 0);
    chk(!addr_ready && !dat_ready, "R5", "readies with no input valid",
        int'({addr_ready, dat_ready}), 0);

    // Latency: one beat into an empty pipeline, both banks ready.
    nx_r0 = 1'b1; nx_r1 = 1'b1;
    nx_av = 1'b1; nx_dv = 1'b0; nx_addr = 10'h2b7;
    cycle(acc);
    chk(!acc, "R5", "address alone not taken", int'(acc), 0);
    nx_dv = 1'b1;
    cycle(acc);
    chk(acc, "R5", "joined beat taken", int'(acc), 1);
    nx_av = 1'b0; nx_dv = 1'b0;
    cycle(acc);
    chk(!bank0_valid && !bank1_valid, "R6", "not at banks after first edge",
        int'({bank0_valid, bank1_valid}), 0);
    cycle(acc);
    chk(bank0_valid && bank1_valid, "R6", "at both banks after second edge",
        int'({bank0_valid, bank1_valid}), 3);
    cycle(acc);
    chk(!bank0_valid && !bank1_valid, "R7", "valids drop after acceptance",
        int'({bank0_valid, bank1_valid}), 0);

    // Full address sweep with random gaps and independent bank readies.
    lfsr = 16'hace1;
    idx = 0;
    while (idx < (1 << AW)) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      nx_addr = AW'(idx);
      nx_av = lfsr[0] | lfsr[1];
      nx_dv = lfsr[2] | lfsr[3];
      nx_r0 = lfsr[4] | lfsr[5];
      nx_r1 = lfsr[6] | lfsr[8];
      cycle(acc);
      if (acc) idx++;
    end
    nx_av = 1'b0; nx_dv = 1'b0; nx_r0 = 1'b1; nx_r1 = 1'b1;
    repeat (6) cycle(acc);
    chk(rd0 == wr && rd1 == wr, "R9", "sweep drained, bank0 count", rd0, wr);
    chk(rd1 == wr, "R9", "sweep drained, bank1 count", rd1, wr);

    // Hold bank 1 stalled while input streams stay valid.
    w0 = wr; r0s = rd0; r1s = rd1;
    nx_r0 = 1'b1; nx_r1 = 1'b0;
    nx_av = 1'b1; nx_dv = 1'b1;
    idx = 10'h155;
    repeat (20) begin
      nx_addr = AW'(idx);
      cycle(acc);
      if (acc) idx++;
    end
    chk(wr - w0 == 2, "R8", "beats accepted under stall", wr - w0, 2);
    chk(rd0 - r0s == 1, "R8", "bank0 beats under stall", rd0 - r0s, 1);
    chk(rd1 == r1s, "R8", "bank1 beats under stall", rd1 - r1s, 0);
    chk(!bank0_valid && bank1_valid, "R7", "bank0 idle, bank1 held",
        int'({bank1_valid, bank0_valid}), 2);
    chk(!addr_ready && !dat_ready, "R8", "input closed", int'({addr_ready, dat_ready}), 0);
    nx_r1 = 1'b1; nx_av = 1'b0; nx_dv = 1'b0;
    repeat (6) cycle(acc);
    chk(rd0 == wr, "R9", "final bank0 count", rd0, wr);
    chk(rd1 == wr, "R9", "final bank1 count", rd1, wr);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule